// File: doc/BRIEF.md
# GPIO Interrupt Detector

This unit watches eight already-synchronized general-purpose input pins and turns activity on them into interrupt requests. Each pin has its own trigger setting: it can respond to a steady level (high or low) or to a transition (rising, falling, or either). Transitions are remembered in a sticky status bit until software clears it. Levels are not remembered and simply track the pin.

Software sees the unit as a small bank of word-aligned registers. There are four configuration registers, two read-only status views (raw and masked by the enable register) and a write-one-to-clear register for edge events. All masked status bits are ORed into one registered interrupt line for the system interrupt controller.

The register port is a plain single-cycle access. A write takes effect on the clock edge where `reg_wr_en` is high. Read data is a combinational function of `reg_addr` and the current state, so there is no handshake and no back-pressure. Pin inputs are sampled on every clock.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the enable, level-select, polarity and dual-edge registers read 0, the raw status reads 0 with all pins low, and `irq_out` is 0.
- R2: A pin whose level-select bit (offset 0x04) is 1 is level sensitive. Its raw status bit is 1 exactly while the pin equals its polarity bit (offset 0x08, 1 = active high, 0 = active low), and it follows the pin combinationally with no latching.
- R3: A pin whose level-select bit is 0 and whose dual-edge bit (offset 0x0C) is 0 is edge sensitive. Polarity 1 catches rising transitions and polarity 0 catches falling ones. A transition is seen when the pin differs from its value one clock earlier. The sticky status bit sets on that clock edge and reads 1 from then on.
- R4: A dual-edge bit of 1 makes an edge-mode pin catch both transitions, and its polarity bit then has no effect.
- R5: Writing offset 0x18 clears each sticky edge bit whose write-data bit is 1. Bits written 0 keep their value.
- R6: If a transition is caught on a pin in the same cycle that a clear write targets that pin, the sticky bit stays set.
- R7: The masked status (offset 0x14) is the raw status (offset 0x10) ANDed with the enable register (offset 0x00).
- R8: `irq_out` equals the OR of the masked status bits one clock earlier.
- R9: Writes to 0x10 and 0x14 change nothing. Offset 0x18 and every unmapped offset read 0.
- R10: Rewriting level-select, polarity or dual-edge does not clear sticky edge bits. A bit hidden by level mode reappears when the pin returns to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Synchronized pin levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The bench aims at a clear write that lands in the same cycle as a new transition. A design that lets the clear win would drop that event, and the raw status would read 0 where 1 is expected. It sets polarity against the dual-edge bit, so a design that still honours polarity in dual mode misses one direction of transition. It switches pins between level and edge mode while edge bits are latched, which exposes a design that wipes sticky state on a configuration write. It also writes to the read-only offsets and reads the clear offset, so any aliasing of those addresses shows up as a corrupted status or a non-zero read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 5;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFF_ENABLE    = 5'h00,
    OFF_LEVEL_SEL = 5'h04,
    OFF_POLARITY  = 5'h08,
    OFF_DUAL_EDGE = 5'h0C,
    OFF_RAW       = 5'h10,
    OFF_MASKED    = 5'h14,
    OFF_CLEAR     = 5'h18
  } reg_off_e;

  localparam int unsigned NUM_CFG = 4;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PINS-1:0]       wdata,
  output logic [PINS-1:0]       en_q,
  output logic [PINS-1:0]       lvl_q,
  output logic [PINS-1:0]       pol_q,
  output logic [PINS-1:0]       dual_q,
  output logic [PINS-1:0]       clr_vec
);
  localparam logic [NUM_CFG*REG_ADDR_W-1:0] CFG_OFFS =
    {OFF_DUAL_EDGE, OFF_POLARITY, OFF_LEVEL_SEL, OFF_ENABLE};

  logic [NUM_CFG-1:0][PINS-1:0] cfg_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[g] <= '0;
      else if (wr_en && (addr == CFG_OFFS[g*REG_ADDR_W +: REG_ADDR_W]))
        cfg_q[g] <= wdata;
    end
  end

  assign en_q    = cfg_q[0];
  assign lvl_q   = cfg_q[1];
  assign pol_q   = cfg_q[2];
  assign dual_q  = cfg_q[3];
  assign clr_vec = (wr_en && (addr == OFF_CLEAR)) ? wdata : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] lvl_q,
  input  logic [PINS-1:0] pol_q,
  input  logic [PINS-1:0] dual_q,
  input  logic [PINS-1:0] clr_vec,
  output logic [PINS-1:0] raw_stat,
  output logic [PINS-1:0] edge_stat
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic prev_q;
    logic sticky_q;
    logic rise;
    logic fall;
    logic hit;
    logic lvl_active;

    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_in[g];
    end

    assign rise = pin_in[g] & ~prev_q;
    assign fall = ~pin_in[g] & prev_q;

    always_comb begin
      if (lvl_q[g])       hit = 1'b0;
      else if (dual_q[g]) hit = rise | fall;
      else if (pol_q[g])  hit = rise;
      else                hit = fall;
    end

    // a fresh transition outranks a same-cycle clear
    always_ff @(posedge clk) begin
      if (!rst_n) sticky_q <= 1'b0;
      else        sticky_q <= (sticky_q & ~clr_vec[g]) | hit;
    end

    assign lvl_active   = pol_q[g] ? pin_in[g] : ~pin_in[g];
    assign raw_stat[g]  = lvl_q[g] ? lvl_active : sticky_q;
    assign edge_stat[g] = sticky_q;
  end
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] raw_stat,
  input  logic [PINS-1:0] en_q,
  output logic [PINS-1:0] mask_stat,
  output logic            irq_q
);
  assign mask_stat = raw_stat & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |mask_stat;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PINS-1:0]       pin_in,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]       reg_wdata,
  output logic [PINS-1:0]       reg_rdata,
  output logic                  irq_out
);
  logic [PINS-1:0] en_q, lvl_q, pol_q, dual_q, clr_vec;
  logic [PINS-1:0] raw_stat, edge_stat, mask_stat;

  gpio_irq_cfg #(.PINS(PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .en_q(en_q), .lvl_q(lvl_q), .pol_q(pol_q),
    .dual_q(dual_q), .clr_vec(clr_vec)
  );

  gpio_irq_detect #(.PINS(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl_q(lvl_q),
    .pol_q(pol_q), .dual_q(dual_q), .clr_vec(clr_vec),
    .raw_stat(raw_stat), .edge_stat(edge_stat)
  );

  gpio_irq_combine #(.PINS(PINS)) u_cmb (
    .clk(clk), .rst_n(rst_n), .raw_stat(raw_stat), .en_q(en_q),
    .mask_stat(mask_stat), .irq_q(irq_out)
  );

  always_comb begin
    case (reg_addr)
      OFF_ENABLE:    reg_rdata = en_q;
      OFF_LEVEL_SEL: reg_rdata = lvl_q;
      OFF_POLARITY:  reg_rdata = pol_q;
      OFF_DUAL_EDGE: reg_rdata = dual_q;
      OFF_RAW:       reg_rdata = raw_stat;
      OFF_MASKED:    reg_rdata = mask_stat;
      default:       reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PINS-1:0]       pin_in,
  input logic                  reg_wr_en,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [PINS-1:0]       reg_wdata,
  input logic [PINS-1:0]       lvl_q,
  input logic [PINS-1:0]       pol_q,
  input logic [PINS-1:0]       dual_q,
  input logic [PINS-1:0]       raw_stat,
  input logic [PINS-1:0]       edge_stat,
  input logic [PINS-1:0]       mask_stat,
  input logic                  irq_out
);
  logic [PINS-1:0] pin_d;
  logic [PINS-1:0] clr_req;
  logic [PINS-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_d <= '0;
    else        pin_d <= pin_in;
  end

  assign clr_req = (reg_wr_en && (reg_addr == OFF_CLEAR)) ? reg_wdata : '0;
  assign hit = ~lvl_q & (((dual_q | pol_q) & pin_in & ~pin_d) |
                         ((dual_q | ~pol_q) & ~pin_in & pin_d));

  // R6
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((edge_stat & $past(hit)) == $past(hit)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_stat) & ~edge_stat & ~$past(clr_req)) == '0));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_stat ^ ~(pin_in ^ pol_q)) & lvl_q) == '0);

  // R7
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stat & ~raw_stat) == '0);

  // R8
  irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == (|$past(mask_stat))));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .lvl_q(lvl_q),
  .pol_q(pol_q), .dual_q(dual_q), .raw_stat(raw_stat),
  .edge_stat(edge_stat), .mask_stat(mask_stat), .irq_out(irq_out)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;
  localparam logic [4:0] A_EN = 5'h00, A_LVL = 5'h04, A_POL = 5'h08,
                         A_DUAL = 5'h0C, A_RAW = 5'h10, A_MSK = 5'h14,
                         A_CLR = 5'h18, A_BAD = 5'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       reg_wr_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] m_en = 0, m_lvl = 0, m_pol = 0, m_dual = 0, m_stk = 0, m_prev = 0;
  logic       m_irq = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] m_raw(input logic [7:0] pins);
    return (m_lvl & ~(pins ^ m_pol)) | (~m_lvl & m_stk);
  endfunction

  function automatic logic [7:0] m_read(input logic [4:0] a, input logic [7:0] pins);
    case (a)
      A_EN:    return m_en;
      A_LVL:   return m_lvl;
      A_POL:   return m_pol;
      A_DUAL:  return m_dual;
      A_RAW:   return m_raw(pins);
      A_MSK:   return m_raw(pins) & m_en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check, advance the model across one posedge
  task automatic cyc(input logic [7:0] pins, input bit wr, input logic [4:0] a,
                     input logic [7:0] wd, input string tag);
    logic [7:0] rise, fall, hit, clr;
    pin_in = pins; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    #1;
    chk(tag, reg_rdata, m_read(a, pins));
    chk("R8", {7'b0, irq_out}, {7'b0, m_irq});
    rise = pins & ~m_prev;
    fall = ~pins & m_prev;
    hit  = ~m_lvl & (((m_dual | m_pol) & rise) | ((m_dual | ~m_pol) & fall));
    clr  = (wr && a == A_CLR) ? wd : 8'h00;
    m_irq  = |(m_raw(pins) & m_en);
    m_stk  = (m_stk & ~clr) | hit;
    m_prev = pins;
    if (wr) begin
      case (a)
        A_EN:   m_en = wd;
        A_LVL:  m_lvl = wd;
        A_POL:  m_pol = wd;
        A_DUAL: m_dual = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] pins, input logic [4:0] a, input string tag);
    cyc(pins, 1'b0, a, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] pins, input logic [4:0] a, input logic [7:0] d, input string tag);
    cyc(pins, 1'b1, a, d, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [4:0] a;
    logic [7:0] p;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, A_EN,   "R1");
    rd(8'h00, A_LVL,  "R1");
    rd(8'h00, A_POL,  "R1");
    rd(8'h00, A_DUAL, "R1");
    rd(8'h00, A_RAW,  "R1");

    // R2: level mode on low nibble, mixed polarity, not latched
    wr(8'h00, A_EN,  8'hFF, "R7");
    wr(8'h00, A_LVL, 8'h0F, "R2");
    wr(8'h00, A_POL, 8'h05, "R2");
    rd(8'h00, A_RAW, "R2");
    rd(8'h0F, A_RAW, "R2");
    rd(8'h03, A_MSK, "R7");
    rd(8'h00, A_RAW, "R2");

    // R3: single-edge mode, bit0 rising, bit1 falling
    wr(8'h00, A_LVL, 8'h00, "R3");
    wr(8'h00, A_POL, 8'h01, "R3");
    wr(8'h00, A_CLR, 8'hFF, "R5");
    rd(8'h03, A_RAW, "R3");
    rd(8'h00, A_RAW, "R3");
    rd(8'h00, A_RAW, "R3");

    // R4: dual edge overrides polarity on bit7
    wr(8'h00, A_DUAL, 8'h80, "R4");
    wr(8'h00, A_CLR,  8'hFF, "R4");
    rd(8'h80, A_RAW, "R4");
    wr(8'h80, A_CLR, 8'h80, "R4");
    rd(8'h00, A_RAW, "R4");
    rd(8'h00, A_RAW, "R4");

    // R5: writing zeros has no effect, ones clear only their bits
    rd(8'h03, A_RAW, "R5");
    wr(8'h00, A_CLR, 8'h00, "R5");
    rd(8'h00, A_RAW, "R5");
    wr(8'h00, A_CLR, 8'h01, "R5");
    rd(8'h00, A_RAW, "R5");

    // R6: rising edge on bit2 coincides with a clear of bit2
    wr(8'h00, A_POL, 8'h05, "R6");
    wr(8'h00, A_CLR, 8'hFF, "R6");
    wr(8'h04, A_CLR, 8'h04, "R6");
    rd(8'h04, A_RAW, "R6");

    // R9: read-only and write-only offsets
    wr(8'h04, A_RAW, 8'h00, "R9");
    wr(8'h04, A_MSK, 8'h00, "R9");
    rd(8'h04, A_RAW, "R9");
    rd(8'h04, A_CLR, "R9");
    rd(8'h04, A_BAD, "R9");

    // R10: latched bits survive configuration changes
    wr(8'h04, A_POL,  8'h00, "R10");
    wr(8'h04, A_DUAL, 8'hFF, "R10");
    wr(8'h04, A_LVL,  8'h04, "R10");
    rd(8'h04, A_RAW, "R10");
    wr(8'h04, A_LVL,  8'h00, "R10");
    rd(8'h04, A_RAW, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      a = 5'(($urandom % 8) * 4);
      p = ($urandom % 4 == 0) ? 8'($urandom) : pin_in ^ (8'h1 << ($urandom % 8));
      if ($urandom % 10 < 3) begin
        wr(p, a, 8'($urandom), "R10");
      end else begin
        case (a)
          A_RAW:   rd(p, a, "R3");
          A_MSK:   rd(p, a, "R7");
          A_CLR:   rd(p, a, "R9");
          default: rd(p, a, "R10");
        endcase
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule